// File: doc/BRIEF.md
# Scratchpad memory command controller

This block is the memory-function layer of a single-wire EEPROM slave. A ROM-selection layer ahead of it handles addressing on the shared wire. When that layer finishes, it pulses `rom_done`. The controller then takes one command byte and serves that command until the next wire reset. Bytes arrive on a strobed receive port. Bytes going out to the master are produced one per request on a strobed transmit port. A separate `wire_reset` pulse marks a reset pulse seen on the wire.

Behind the controller sit five stores, all held in plain registers:

- a 32-byte data scratchpad;
- a 32-byte data store that stands in for the non-volatile page;
- an 8-byte register scratchpad;
- an 8-byte application register that can be programmed once;
- a derived status byte.

Every copy command must be confirmed by a validation key byte. Locking the application register is permanent until power-on reset. After the lock, application-register reads come from the locked copy instead of the register scratchpad. The time a copy into the data store takes is modelled as a `copy_busy` pulse of `COPY_CYCLES` clocks.

The sequencer has eight states:

- IDLE: waits for `rom_done`.
- CMD: decodes the command byte.
- ADDR: takes the start address.
- WRITE: accepts data bytes.
- READ: returns data bytes.
- KEY: checks the validation key.
- STATUS: returns the status byte.
- HALT: ignores everything.

The transitions are:

- IDLE to CMD on `rom_done` while not busy.
- CMD to ADDR on a write, read or read-memory command.
- CMD to KEY on a copy, copy-and-lock or status command.
- CMD to HALT on any other byte.
- ADDR to WRITE or READ on the address byte.
- KEY to STATUS on a good status key.
- KEY to HALT on any other key outcome.
- Any state to IDLE on `wire_reset`.

Top module: `ow_memfn_ctrl`

## Requirements
- R1: Received bytes are ignored in IDLE. A `rom_done` pulse moves the block to CMD. A `wire_reset` pulse returns it to IDLE from any state. A transmit request made outside READ and STATUS returns FFh.
- R2: The command codes are 0Fh, AAh, 55h, F0h, 99h, 66h, C3h and 5Ah. Any other command byte sends the block to HALT, where all bytes are ignored and requests return FFh until `wire_reset`.
- R3: Command 0Fh takes a start address, of which only bits 4:0 are used. Each following byte is written to the data scratchpad, and the address then increments, wrapping from 1Fh to 00h.
- R4: Command AAh takes a start address (bits 4:0). Each transmit request returns the data scratchpad byte at the address, and the address then increments, wrapping from 1Fh to 00h.
- R5: Command 55h followed by key A5h copies all 32 scratchpad bytes into the data store. `copy_busy` is then high for exactly `COPY_CYCLES` clocks, starting the cycle after the key byte.
- R6: Command F0h copies the whole data store into the scratchpad as soon as the command byte is received, even if no address follows. It then reads like AAh.
- R7: Command 99h takes a start address, of which only bits 2:0 are used. Each following byte is written to the register scratchpad, with the address wrapping from 7h to 0h. While the register is locked, these bytes are discarded.
- R8: Command 66h followed by key 00h returns the status byte on every request. The status byte is FFh while unlocked and FCh once locked.
- R9: Command C3h takes a start address (bits 2:0) and reads with a wrap from 7h to 0h. While unlocked it returns register scratchpad bytes; once locked it returns application register bytes.
- R10: Command 5Ah followed by key A5h copies the register scratchpad into the application register and sets the lock, which never clears. A wire reset sent in place of the key cancels the command. The command has no effect once the register is locked.
- R11: A wrong validation key after 55h, 5Ah or 66h sends the block to HALT, with no copy, no lock and no status output.
- R12: Every transmit request is answered by a `tx_stb` pulse carrying `tx_byte` in the next cycle. `tx_stb` never pulses otherwise.
- R13: While `copy_busy` is high, `rom_done` is ignored, so the block stays in IDLE.
- R14: After `rst_n`, all stores read 00h, the register is unlocked, `copy_busy` is low, `tx_stb` is low and `tx_byte` is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wire_reset | input | 1 | Pulse: reset pulse seen on the wire |
| rom_done | input | 1 | Pulse: ROM selection completed |
| rx_stb | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| tx_pull | input | 1 | Request for the next byte to transmit |
| tx_stb | output | 1 | Transmit byte valid (one cycle after request) |
| tx_byte | output | 8 | Byte to transmit |
| copy_busy | output | 1 | High while the data-store copy is in progress |

## Verification
The bench targets five corner cases:

- Address wrap at 1Fh and at 7h, using start addresses whose upper bits are set. A design that masked the address wrongly would write or return bytes at the wrong places.
- The read-memory reload when no address follows. A design that delayed the reload until the address byte would leave stale scratchpad data.
- Lock behaviour: a cancelled lock, a real lock, a second lock attempt and a write after the lock. A design that got any of these wrong would show a changed status byte or altered register contents.
- Wrong keys. These must silence the block, so a design that let later bytes through would alter stored data.
- Activation attempts during the busy pulse. A design that accepted them would answer a read with data instead of FFh.

// File: rtl/ow_memfn_pkg.sv
package ow_memfn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_KEY,
        ST_STATUS,
        ST_HALT
    } fsm_state_t;

    localparam logic [7:0] OP_WR_SP   = 8'h0F;
    localparam logic [7:0] OP_RD_SP   = 8'hAA;
    localparam logic [7:0] OP_CP_SP   = 8'h55;
    localparam logic [7:0] OP_RD_MEM  = 8'hF0;
    localparam logic [7:0] OP_WR_REG  = 8'h99;
    localparam logic [7:0] OP_RD_STAT = 8'h66;
    localparam logic [7:0] OP_RD_REG  = 8'hC3;
    localparam logic [7:0] OP_LOCK    = 8'h5A;

    localparam logic [7:0] KEY_COPY   = 8'hA5;
    localparam logic [7:0] KEY_STAT   = 8'h00;

    localparam logic [7:0] STAT_OPEN  = 8'hFF;
    localparam logic [7:0] STAT_SHUT  = 8'hFC;
    localparam logic [7:0] IDLE_BYTE  = 8'hFF;

endpackage

// File: rtl/ow_memfn_store.sv
module ow_memfn_store #(
    parameter int DATA_BYTES = 32,
    parameter int REG_BYTES  = 8,
    localparam int DATA_AW   = $clog2(DATA_BYTES),
    localparam int REG_AW    = $clog2(REG_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_AW-1:0] addr,
    input  logic [7:0]         wdata,
    input  logic               sp_we,
    input  logic               rg_we,
    input  logic               load_sp,
    input  logic               copy_sp,
    input  logic               lock_reg,
    output logic [7:0]         sp_rdata,
    output logic [7:0]         rg_rdata,
    output logic               locked
);

    logic [7:0] sp_q  [DATA_BYTES];
    logic [7:0] st_q  [DATA_BYTES];
    logic [7:0] rsp_q [REG_BYTES];
    logic [7:0] app_q [REG_BYTES];
    logic       locked_q;

    logic [8*REG_BYTES-1:0] app_flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_BYTES; i++) begin
                sp_q[i] <= '0;
                st_q[i] <= '0;
            end
            for (int j = 0; j < REG_BYTES; j++) begin
                rsp_q[j] <= '0;
                app_q[j] <= '0;
            end
            locked_q <= 1'b0;
        end else begin
            if (load_sp) begin
                for (int i = 0; i < DATA_BYTES; i++) sp_q[i] <= st_q[i];
            end else if (sp_we) begin
                sp_q[addr] <= wdata;
            end
            if (copy_sp) begin
                for (int i = 0; i < DATA_BYTES; i++) st_q[i] <= sp_q[i];
            end
            if (rg_we) rsp_q[addr[REG_AW-1:0]] <= wdata;
            if (lock_reg) begin
                for (int j = 0; j < REG_BYTES; j++) app_q[j] <= rsp_q[j];
                locked_q <= 1'b1;
            end
        end
    end

    always_comb begin
        for (int j = 0; j < REG_BYTES; j++) app_flat[8*j +: 8] = app_q[j];
    end

    assign sp_rdata = sp_q[addr];
    assign rg_rdata = locked_q ? app_q[addr[REG_AW-1:0]] : rsp_q[addr[REG_AW-1:0]];
    assign locked   = locked_q;

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(locked_q));

    // R10
    app_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked_q) |-> $stable(app_flat));

endmodule

// File: rtl/ow_memfn_timer.sv
module ow_memfn_timer #(
    parameter int CYCLES = 20_000_000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R13
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/ow_memfn_fsm.sv
module ow_memfn_fsm
    import ow_memfn_pkg::*;
#(
    parameter int DATA_AW = 5,
    parameter int REG_AW  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wire_reset,
    input  logic               rom_done,
    input  logic               busy,
    input  logic               rx_stb,
    input  logic [7:0]         rx_byte,
    input  logic               tx_pull,
    input  logic               locked,
    input  logic [7:0]         sp_rdata,
    input  logic [7:0]         rg_rdata,
    output logic               tx_stb,
    output logic [7:0]         tx_byte,
    output logic [DATA_AW-1:0] addr,
    output logic               sp_we,
    output logic               rg_we,
    output logic               load_sp,
    output logic               copy_sp,
    output logic               lock_reg,
    output logic               copy_start
);

    fsm_state_t         state_q, state_d;
    logic [7:0]         op_q, op_d;
    logic [DATA_AW-1:0] addr_q, addr_d, addr_nx;
    logic               is_reg;
    logic [7:0]         tx_byte_d;
    logic               tx_stb_q;
    logic [7:0]         tx_byte_q;

    assign is_reg  = (op_q == OP_WR_REG) || (op_q == OP_RD_REG);
    assign addr_nx = is_reg ? {{(DATA_AW-REG_AW){1'b0}}, addr_q[REG_AW-1:0] + 1'b1}
                            : addr_q + 1'b1;

    always_comb begin
        state_d    = state_q;
        op_d       = op_q;
        addr_d     = addr_q;
        sp_we      = 1'b0;
        rg_we      = 1'b0;
        load_sp    = 1'b0;
        copy_sp    = 1'b0;
        lock_reg   = 1'b0;
        copy_start = 1'b0;
        if (wire_reset) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (rom_done && !busy) state_d = ST_CMD;
                ST_CMD: if (rx_stb) begin
                    op_d = rx_byte;
                    case (rx_byte)
                        OP_WR_SP, OP_RD_SP, OP_WR_REG, OP_RD_REG: state_d = ST_ADDR;
                        OP_RD_MEM: begin
                            load_sp = 1'b1;
                            state_d = ST_ADDR;
                        end
                        OP_CP_SP, OP_RD_STAT, OP_LOCK: state_d = ST_KEY;
                        default: state_d = ST_HALT;
                    endcase
                end
                ST_ADDR: if (rx_stb) begin
                    addr_d  = is_reg ? {{(DATA_AW-REG_AW){1'b0}}, rx_byte[REG_AW-1:0]}
                                     : rx_byte[DATA_AW-1:0];
                    state_d = (op_q == OP_WR_SP || op_q == OP_WR_REG) ? ST_WRITE : ST_READ;
                end
                ST_WRITE: if (rx_stb) begin
                    if (op_q == OP_WR_SP) sp_we = 1'b1;
                    else                  rg_we = !locked;
                    addr_d = addr_nx;
                end
                ST_READ: if (tx_pull) addr_d = addr_nx;
                ST_KEY: if (rx_stb) begin
                    if (op_q == OP_RD_STAT) begin
                        state_d = (rx_byte == KEY_STAT) ? ST_STATUS : ST_HALT;
                    end else begin
                        state_d = ST_HALT;
                        if (rx_byte == KEY_COPY) begin
                            if (op_q == OP_CP_SP) begin
                                copy_sp    = 1'b1;
                                copy_start = 1'b1;
                            end else begin
                                lock_reg   = !locked;
                            end
                        end
                    end
                end
                ST_STATUS, ST_HALT: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if (state_q == ST_READ)        tx_byte_d = is_reg ? rg_rdata : sp_rdata;
        else if (state_q == ST_STATUS) tx_byte_d = locked ? STAT_SHUT : STAT_OPEN;
        else                           tx_byte_d = IDLE_BYTE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_stb_q  <= 1'b0;
            tx_byte_q <= IDLE_BYTE;
        end else begin
            tx_stb_q <= tx_pull;
            if (tx_pull) tx_byte_q <= tx_byte_d;
        end
    end

    assign tx_stb  = tx_stb_q;
    assign tx_byte = tx_byte_q;
    assign addr    = addr_q;

    // R12
    tx_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pull |=> tx_stb_q);

    // R12
    tx_only_on_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_q |-> $past(tx_pull));

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wire_reset |=> state_q == ST_IDLE);

    // R10
    lock_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_reg |-> !locked);

endmodule

// File: rtl/ow_memfn_ctrl.sv
module ow_memfn_ctrl #(
    parameter int DATA_BYTES  = 32,
    parameter int REG_BYTES   = 8,
    parameter int COPY_CYCLES = 20_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wire_reset,
    input  logic       rom_done,
    input  logic       rx_stb,
    input  logic [7:0] rx_byte,
    input  logic       tx_pull,
    output logic       tx_stb,
    output logic [7:0] tx_byte,
    output logic       copy_busy
);

    localparam int DATA_AW = $clog2(DATA_BYTES);
    localparam int REG_AW  = $clog2(REG_BYTES);

    logic [DATA_AW-1:0] addr;
    logic [7:0]         sp_rdata, rg_rdata;
    logic               sp_we, rg_we, load_sp, copy_sp, lock_reg, copy_start, locked;

    ow_memfn_fsm #(.DATA_AW(DATA_AW), .REG_AW(REG_AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wire_reset (wire_reset),
        .rom_done   (rom_done),
        .busy       (copy_busy),
        .rx_stb     (rx_stb),
        .rx_byte    (rx_byte),
        .tx_pull    (tx_pull),
        .locked     (locked),
        .sp_rdata   (sp_rdata),
        .rg_rdata   (rg_rdata),
        .tx_stb     (tx_stb),
        .tx_byte    (tx_byte),
        .addr       (addr),
        .sp_we      (sp_we),
        .rg_we      (rg_we),
        .load_sp    (load_sp),
        .copy_sp    (copy_sp),
        .lock_reg   (lock_reg),
        .copy_start (copy_start)
    );

    ow_memfn_store #(.DATA_BYTES(DATA_BYTES), .REG_BYTES(REG_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (rx_byte),
        .sp_we    (sp_we),
        .rg_we    (rg_we),
        .load_sp  (load_sp),
        .copy_sp  (copy_sp),
        .lock_reg (lock_reg),
        .sp_rdata (sp_rdata),
        .rg_rdata (rg_rdata),
        .locked   (locked)
    );

    ow_memfn_timer #(.CYCLES(COPY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (copy_start),
        .busy  (copy_busy)
    );

endmodule

// File: tb/ow_memfn_ctrl_test.sv
`timescale 1ns/1ps
module ow_memfn_ctrl_test;

    localparam int CYC = 40;
    localparam int M_IDLE = 0, M_CMD = 1, M_ADDR = 2, M_WR = 3,
                   M_RD = 4, M_KEY = 5, M_STAT = 6, M_HALT = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wire_reset = 1'b0, rom_done = 1'b0, rx_stb = 1'b0, tx_pull = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_stb, copy_busy;
    logic [7:0] tx_byte;

    int    checks = 0, errors = 0;
    bit    done = 0;
    string tag = "R14";

    always #2.5 clk = ~clk;

    ow_memfn_ctrl #(.COPY_CYCLES(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .wire_reset(wire_reset), .rom_done(rom_done),
        .rx_stb(rx_stb), .rx_byte(rx_byte), .tx_pull(tx_pull),
        .tx_stb(tx_stb), .tx_byte(tx_byte), .copy_busy(copy_busy)
    );

    // behavioural reference model
    int         m_mode, m_addr, m_busy;
    logic [7:0] m_op;
    logic [7:0] m_sp [32];
    logic [7:0] m_st [32];
    logic [7:0] m_rsp [8];
    logic [7:0] m_app [8];
    bit         m_lock, busy_now, m_reg;
    bit         e_stb, e_busy;
    logic [7:0] e_byte;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = M_IDLE; m_addr = 0; m_busy = 0; m_op = 0; m_lock = 0;
            foreach (m_sp[i]) begin m_sp[i] = 0; m_st[i] = 0; end
            foreach (m_rsp[i]) begin m_rsp[i] = 0; m_app[i] = 0; end
            e_stb = 0; e_busy = 0; e_byte = 8'hFF;
        end else begin
            busy_now = (m_busy > 0);
            m_reg = (m_op == 8'h99) || (m_op == 8'hC3);
            e_stb = tx_pull;
            if (tx_pull) begin
                if (m_mode == M_RD)
                    e_byte = m_reg ? (m_lock ? m_app[m_addr % 8] : m_rsp[m_addr % 8]) : m_sp[m_addr];
                else if (m_mode == M_STAT)
                    e_byte = m_lock ? 8'hFC : 8'hFF;
                else
                    e_byte = 8'hFF;
            end
            if (m_busy > 0) m_busy--;
            if (wire_reset) m_mode = M_IDLE;
            else case (m_mode)
                M_IDLE: if (rom_done && !busy_now) m_mode = M_CMD;
                M_CMD: if (rx_stb) begin
                    m_op = rx_byte;
                    if (rx_byte == 8'h0F || rx_byte == 8'hAA || rx_byte == 8'h99 || rx_byte == 8'hC3)
                        m_mode = M_ADDR;
                    else if (rx_byte == 8'hF0) begin
                        foreach (m_sp[i]) m_sp[i] = m_st[i];
                        m_mode = M_ADDR;
                    end else if (rx_byte == 8'h55 || rx_byte == 8'h66 || rx_byte == 8'h5A)
                        m_mode = M_KEY;
                    else m_mode = M_HALT;
                end
                M_ADDR: if (rx_stb) begin
                    m_addr = m_reg ? rx_byte % 8 : rx_byte % 32;
                    m_mode = (m_op == 8'h0F || m_op == 8'h99) ? M_WR : M_RD;
                end
                M_WR: if (rx_stb) begin
                    if (m_op == 8'h0F) m_sp[m_addr] = rx_byte;
                    else if (!m_lock)  m_rsp[m_addr] = rx_byte;
                    m_addr = m_reg ? (m_addr + 1) % 8 : (m_addr + 1) % 32;
                end
                M_RD: if (tx_pull) m_addr = m_reg ? (m_addr + 1) % 8 : (m_addr + 1) % 32;
                M_KEY: if (rx_stb) begin
                    if (m_op == 8'h66) m_mode = (rx_byte == 8'h00) ? M_STAT : M_HALT;
                    else begin
                        m_mode = M_HALT;
                        if (rx_byte == 8'hA5) begin
                            if (m_op == 8'h55) begin
                                foreach (m_st[i]) m_st[i] = m_sp[i];
                                m_busy = CYC;
                            end else if (!m_lock) begin
                                foreach (m_app[i]) m_app[i] = m_rsp[i];
                                m_lock = 1;
                            end
                        end
                    end
                end
                default: ;
            endcase
            e_busy = (m_busy > 0);
        end
    end

    task automatic check(string t, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", t, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({tag, " tx_stb"}, {7'd0, tx_stb}, {7'd0, e_stb});
            check({tag, " copy_busy"}, {7'd0, copy_busy}, {7'd0, e_busy});
            if (e_stb) check({tag, " tx_byte"}, tx_byte, e_byte);
        end
    end

    task automatic send(logic [7:0] b);
        @(negedge clk); rx_stb = 1; rx_byte = b;
        @(negedge clk); rx_stb = 0;
    endtask
    task automatic pull(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tx_pull = 1;
            @(negedge clk); tx_pull = 0;
        end
    endtask
    task automatic act();
        @(negedge clk); rom_done = 1;
        @(negedge clk); rom_done = 0;
    endtask
    task automatic wrst();
        @(negedge clk); wire_reset = 1;
        @(negedge clk); wire_reset = 0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        tag = "R14";
        check("R14 reset tx_stb", {7'd0, tx_stb}, 8'h00);
        check("R14 reset copy_busy", {7'd0, copy_busy}, 8'h00);
        check("R14 reset tx_byte", tx_byte, 8'hFF);
        act(); send(8'hAA); send(8'h00); pull(3); wrst();
        act(); send(8'hC3); send(8'h00); pull(2); wrst();

        tag = "R1";
        send(8'h0F); send(8'h00); send(8'h77); pull(2);
        act(); pull(1); send(8'hAA); pull(1); send(8'h00); pull(2); wrst();

        tag = "R3";
        act(); send(8'h0F); send(8'hFE);
        send(8'h11); send(8'h22); send(8'h33); send(8'h44); wrst();

        tag = "R4";
        act(); send(8'hAA); send(8'h3E); pull(5); wrst();

        tag = "R5";
        act(); send(8'h55); send(8'hA5); send(8'h0F); pull(1);
        tag = "R13";
        wrst(); act(); send(8'hAA); send(8'h1E); pull(2);
        idle(CYC); wrst();

        tag = "R6";
        act(); send(8'h0F); send(8'h1F); send(8'h99); send(8'h98); wrst();
        act(); send(8'hF0); wrst();
        act(); send(8'hAA); send(8'h1E); pull(4); wrst();
        act(); send(8'h0F); send(8'h00); send(8'h5C); wrst();
        act(); send(8'hF0); send(8'hDF); pull(3); wrst();

        tag = "R7";
        act(); send(8'h99); send(8'hFD);
        for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i));
        wrst();
        tag = "R9";
        act(); send(8'hC3); send(8'h06); pull(9); wrst();

        tag = "R8";
        act(); send(8'h66); send(8'h00); pull(3); wrst();

        tag = "R11";
        act(); send(8'h0F); send(8'h00); send(8'hEE); wrst();
        act(); send(8'h55); send(8'hA4); send(8'h0F); send(8'h00); pull(1); wrst();
        act(); send(8'hF0); send(8'h00); pull(2); wrst();
        act(); send(8'h66); send(8'h01); pull(2); wrst();
        act(); send(8'h5A); send(8'h00); wrst();
        act(); send(8'h66); send(8'h00); pull(1); wrst();

        tag = "R10";
        act(); send(8'h5A); wrst();
        act(); send(8'h66); send(8'h00); pull(1); wrst();
        act(); send(8'h5A); send(8'hA5); pull(1); wrst();
        act(); send(8'h66); send(8'h00); pull(2); wrst();
        act(); send(8'hC3); send(8'h00); pull(8); wrst();
        act(); send(8'hAA); send(8'h00); pull(1); wrst();
        tag = "R7";
        act(); send(8'h99); send(8'h00); send(8'h01); send(8'h02); wrst();
        tag = "R10";
        act(); send(8'h5A); send(8'hA5); wrst();
        act(); send(8'hC3); send(8'h00); pull(8); wrst();

        tag = "R2";
        act(); send(8'h12); send(8'h0F); send(8'h00); pull(2); wrst();
        act(); send(8'hAA); send(8'h00); pull(2); wrst();

        tag = "R12";
        act(); send(8'hAA); send(8'h05); pull(3); idle(4); wrst();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired at tag %s", tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule